// File: doc/BRIEF.md
# PPS-Disciplined Seconds/Ticks Timebase

This block keeps wall-clock time as two 32-bit counts: whole seconds and ticks inside the current second. The tick count advances on every clock and rolls over at a programmable ticks-per-second value. Each rollover adds one to the seconds count. Software sets the time through a small indexed settings-write path. It first stages a seconds value and a ticks value, then writes a commit word. The commit either applies the staged time on that clock edge or arms a load for the next pulse-per-second (PPS) edge.

Two PPS inputs are available: a connector input and a secondary sync input. Each passes through its own synchronizer. A settings field picks the source and another picks rising or falling edge. On every selected PPS edge the block records the live seconds and ticks in a snapshot pair. A 32-bit read port returns the live pair or the snapshot pair. The live pair is also driven out continuously for local consumers.

Top module: `pps_timebase`

## Requirements
- R1: While reset is asserted, and for two clock edges after the asynchronous active-low reset is released, live seconds, live ticks and both snapshot words read 0. Ticks-per-second then equals the TPS_RESET parameter. The edge select is rising, the source is the connector input and no load is pending.
- R2: Ticks increase by one on each clock edge. On an edge where ticks+1 is at least ticks-per-second, ticks return to 0 and seconds increase by one on the same edge.
- R3: A write (cfg_we high) stores cfg_data according to cfg_idx. Index 0 stages seconds, index 1 stages ticks, index 2 sets flags, index 3 is the commit word and index 4 sets ticks-per-second. In the flags, bit 0 = 1 selects rising and 0 selects falling, and bit 1 = 0 selects pps_ext while 1 selects pps_alt. Index 5 (multi-unit sync word), 6 and 7 are accepted and have no effect. Staging writes leave the live time unchanged.
- R4: A commit write with bit 0 = 1 loads the staged seconds and ticks into the live counters on the edge that takes the write. Counting resumes from the staged ticks on the next edge.
- R5: A commit write with bit 0 = 0 arms a pending load. The staged time is loaded on the first selected PPS edge acted on after the commit edge, and the pending state then clears. PPS edges with nothing pending do not change the live time.
- R6: A PPS level change present at clock edge k is acted on (snapshot, deferred load) at edge k+SYNC_STAGES. This is the synchronizer depth plus one edge-history register, minus the sampling edge.
- R7: With flags bit 0 = 0, only high-to-low transitions of the selected input count as PPS edges. Low-to-high transitions are ignored.
- R8: Transitions on the unselected PPS input have no effect on snapshot or live time.
- R9: On each PPS edge acted on, the snapshot takes the live seconds and ticks visible just before that edge, including when a load lands on the same edge. Between PPS edges the snapshot holds.
- R10: rd_data is combinational from rd_addr[3:2]: 0 gives live seconds, 1 live ticks, 2 snapshot seconds, 3 snapshot ticks. rd_addr[1:0] are ignored.
- R11: An immediate commit clears any pending deferred load. A deferred commit on the same edge where a PPS edge is acted on (with nothing pending) waits for the following PPS edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Settings write strobe |
| cfg_idx | input | 3 | Settings register index |
| cfg_data | input | 32 | Settings write data |
| pps_ext | input | 1 | PPS from the external connector |
| pps_alt | input | 1 | PPS from the secondary sync input |
| rd_addr | input | 4 | Readback byte offset |
| rd_data | output | 32 | Readback word |
| now_secs | output | 32 | Live seconds count |
| now_ticks | output | 32 | Live ticks count |

## Verification
The bench builds the block with TPS_RESET = 10 and SYNC_STAGES = 2. With these values the rollover and seconds increment occur within ten cycles of reset, before any write. The two-edge PPS latency stays short enough to place a deferred commit exactly on the edge where a PPS edge is acted on. Ticks-per-second is then rewritten to 5 and 7, so seconds roll over often during each PPS phase. Every snapshot then captures a mid-second ticks value, and loads land both just before and just after a rollover.

// File: rtl/tk_pkg.sv
package tk_pkg;

  typedef enum logic [2:0] {
    IDX_SECS    = 3'd0,
    IDX_TICKS   = 3'd1,
    IDX_FLAGS   = 3'd2,
    IDX_COMMIT  = 3'd3,
    IDX_TPS     = 3'd4,
    IDX_SYNCCFG = 3'd5
  } cfg_idx_e;

  typedef struct packed {
    logic src_alt;
    logic rise;
  } pps_cfg_t;

  localparam pps_cfg_t PPS_CFG_RESET = '{src_alt: 1'b0, rise: 1'b1};

  localparam logic [1:0] RD_NOW_SECS  = 2'd0;
  localparam logic [1:0] RD_NOW_TICKS = 2'd1;
  localparam logic [1:0] RD_PPS_SECS  = 2'd2;
  localparam logic [1:0] RD_PPS_TICKS = 2'd3;

endpackage

// File: rtl/tk_rst_sync.sv
module tk_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= chain_d;
  end

  assign rst_sync_n = chain_q[STAGES-1];
endmodule

// File: rtl/tk_pps_front.sv
module tk_pps_front
  import tk_pkg::*;
#(
  parameter int NSRC        = 2,
  parameter int SYNC_STAGES = 2,
  localparam int SEL_W      = (NSRC > 1) ? $clog2(NSRC) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NSRC-1:0]  pps_in,
  input  logic [SEL_W-1:0] src_sel,
  input  logic             rise,
  output logic             pps_edge
);
  logic [NSRC-1:0] synced;

  for (genvar g = 0; g < NSRC; g++) begin : g_sync
    logic [SYNC_STAGES-1:0] sh_q;
    logic [SYNC_STAGES-1:0] sh_d;
    always_comb begin
      sh_d = {sh_q[SYNC_STAGES-2:0], pps_in[g]};
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sh_q <= '0;
      else        sh_q <= sh_d;
    end
    assign synced[g] = sh_q[SYNC_STAGES-1];
  end

  logic sel_lvl;
  logic prev_q;
  logic prev_d;

  always_comb begin
    sel_lvl = synced[src_sel];
    prev_d  = sel_lvl;
    if (rise) pps_edge = sel_lvl & ~prev_q;
    else      pps_edge = ~sel_lvl & prev_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= 1'b0;
    else        prev_q <= prev_d;
  end
endmodule

// File: rtl/tk_settings.sv
module tk_settings
  import tk_pkg::*;
#(
  parameter int          TIME_W    = 32,
  parameter logic [31:0] TPS_RESET = 32'd100_000_000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [2:0]        cfg_idx,
  input  logic [31:0]       cfg_data,
  output logic [TIME_W-1:0] stage_secs,
  output logic [TIME_W-1:0] stage_ticks,
  output logic [TIME_W-1:0] tps,
  output pps_cfg_t          pps_cfg,
  output logic              commit_now,
  output logic              commit_later
);
  cfg_idx_e idx;
  logic en_secs, en_ticks, en_flags, en_tps;

  always_comb begin
    idx          = cfg_idx_e'(cfg_idx);
    en_secs      = cfg_we && (idx == IDX_SECS);
    en_ticks     = cfg_we && (idx == IDX_TICKS);
    en_flags     = cfg_we && (idx == IDX_FLAGS);
    en_tps       = cfg_we && (idx == IDX_TPS);
    commit_now   = cfg_we && (idx == IDX_COMMIT) &&  cfg_data[0];
    commit_later = cfg_we && (idx == IDX_COMMIT) && !cfg_data[0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage_secs  <= '0;
      stage_ticks <= '0;
      tps         <= TIME_W'(TPS_RESET);
      pps_cfg     <= PPS_CFG_RESET;
    end else begin
      if (en_secs)  stage_secs  <= cfg_data[TIME_W-1:0];
      if (en_ticks) stage_ticks <= cfg_data[TIME_W-1:0];
      if (en_tps)   tps         <= cfg_data[TIME_W-1:0];
      if (en_flags) pps_cfg     <= '{src_alt: cfg_data[1], rise: cfg_data[0]};
    end
  end
endmodule

// File: rtl/tk_counter.sv
module tk_counter #(
  parameter int TIME_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [TIME_W-1:0] tps,
  input  logic [TIME_W-1:0] stage_secs,
  input  logic [TIME_W-1:0] stage_ticks,
  input  logic              commit_now,
  input  logic              commit_later,
  input  logic              pps_edge,
  output logic [TIME_W-1:0] secs,
  output logic [TIME_W-1:0] ticks,
  output logic              pending,
  output logic              load_fire
);
  logic [TIME_W:0]   tick_inc;
  logic              wrap;
  logic [TIME_W-1:0] secs_d, ticks_d;
  logic              pend_d;

  always_comb begin
    tick_inc  = {1'b0, ticks} + 1'b1;
    wrap      = tick_inc >= {1'b0, tps};
    load_fire = commit_now | (pending & pps_edge);
    secs_d    = secs;
    ticks_d   = ticks;
    pend_d    = pending;
    if (load_fire) begin
      secs_d  = stage_secs;
      ticks_d = stage_ticks;
    end else if (wrap) begin
      ticks_d = '0;
      secs_d  = secs + 1'b1;
    end else begin
      ticks_d = tick_inc[TIME_W-1:0];
    end
    if (commit_later)   pend_d = 1'b1;
    else if (load_fire) pend_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      secs    <= '0;
      ticks   <= '0;
      pending <= 1'b0;
    end else begin
      secs    <= secs_d;
      ticks   <= ticks_d;
      pending <= pend_d;
    end
  end
endmodule

// File: rtl/tk_capture.sv
module tk_capture #(
  parameter int TIME_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pps_edge,
  input  logic [TIME_W-1:0] secs,
  input  logic [TIME_W-1:0] ticks,
  output logic [TIME_W-1:0] snap_secs,
  output logic [TIME_W-1:0] snap_ticks
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      snap_secs  <= '0;
      snap_ticks <= '0;
    end else if (pps_edge) begin
      snap_secs  <= secs;
      snap_ticks <= ticks;
    end
  end
endmodule

// File: rtl/pps_timebase.sv
module pps_timebase
  import tk_pkg::*;
#(
  parameter int          TIME_W      = 32,
  parameter int          SYNC_STAGES = 2,
  parameter logic [31:0] TPS_RESET   = 32'd100_000_000
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cfg_we,
  input  logic [2:0]  cfg_idx,
  input  logic [31:0] cfg_data,
  input  logic        pps_ext,
  input  logic        pps_alt,
  input  logic [3:0]  rd_addr,
  output logic [31:0] rd_data,
  output logic [31:0] now_secs,
  output logic [31:0] now_ticks
);
  localparam int NSRC = 2;

  logic              rst_sync_n;
  logic [TIME_W-1:0] stage_secs, stage_ticks, tps_q;
  pps_cfg_t          pps_cfg;
  logic              commit_now, commit_later;
  logic              pps_edge, pend_q, load_fire;
  logic [TIME_W-1:0] secs_q, ticks_q, snap_secs, snap_ticks;

  tk_rst_sync #(.STAGES(2)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_sync_n(rst_sync_n)
  );

  tk_settings #(.TIME_W(TIME_W), .TPS_RESET(TPS_RESET)) u_cfg (
    .clk(clk), .rst_n(rst_sync_n), .cfg_we(cfg_we), .cfg_idx(cfg_idx),
    .cfg_data(cfg_data), .stage_secs(stage_secs), .stage_ticks(stage_ticks),
    .tps(tps_q), .pps_cfg(pps_cfg), .commit_now(commit_now),
    .commit_later(commit_later)
  );

  tk_pps_front #(.NSRC(NSRC), .SYNC_STAGES(SYNC_STAGES)) u_pps (
    .clk(clk), .rst_n(rst_sync_n), .pps_in({pps_alt, pps_ext}),
    .src_sel(pps_cfg.src_alt), .rise(pps_cfg.rise), .pps_edge(pps_edge)
  );

  tk_counter #(.TIME_W(TIME_W)) u_cnt (
    .clk(clk), .rst_n(rst_sync_n), .tps(tps_q), .stage_secs(stage_secs),
    .stage_ticks(stage_ticks), .commit_now(commit_now),
    .commit_later(commit_later), .pps_edge(pps_edge), .secs(secs_q),
    .ticks(ticks_q), .pending(pend_q), .load_fire(load_fire)
  );

  tk_capture #(.TIME_W(TIME_W)) u_cap (
    .clk(clk), .rst_n(rst_sync_n), .pps_edge(pps_edge), .secs(secs_q),
    .ticks(ticks_q), .snap_secs(snap_secs), .snap_ticks(snap_ticks)
  );

  always_comb begin
    now_secs  = 32'(secs_q);
    now_ticks = 32'(ticks_q);
    unique case (rd_addr[3:2])
      RD_NOW_SECS:  rd_data = 32'(secs_q);
      RD_NOW_TICKS: rd_data = 32'(ticks_q);
      RD_PPS_SECS:  rd_data = 32'(snap_secs);
      default:      rd_data = 32'(snap_ticks);
    endcase
  end
endmodule

// File: rtl/pps_timebase_chk.sv
module pps_timebase_chk #(
  parameter int TIME_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic [31:0]       now_secs,
  input logic [31:0]       now_ticks,
  input logic [TIME_W-1:0] tps,
  input logic              load_fire,
  input logic              pps_edge,
  input logic              pend,
  input logic              commit_now,
  input logic              commit_later,
  input logic [TIME_W-1:0] snap_secs,
  input logic [TIME_W-1:0] snap_ticks,
  input logic [3:0]        rd_addr,
  input logic [31:0]       rd_data
);
  logic at_end;
  assign at_end = ({1'b0, now_ticks} + 33'd1) >= {1'b0, 32'(tps)};

  p_tick_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!load_fire && !at_end) |=> (now_ticks == $past(now_ticks) + 32'd1) && $stable(now_secs));

  p_rollover_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!load_fire && at_end) |=> (now_ticks == 32'd0) && (now_secs == $past(now_secs) + 32'd1));

  p_snap_take_r9: assert property (@(posedge clk) disable iff (!rst_n)
    pps_edge |=> (32'(snap_secs) == $past(now_secs)) && (32'(snap_ticks) == $past(now_ticks)));

  p_snap_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !pps_edge |=> $stable(snap_secs) && $stable(snap_ticks));

  p_pend_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (pend && pps_edge && !commit_later) |=> !pend);

  p_imm_cancel_r11: assert property (@(posedge clk) disable iff (!rst_n)
    commit_now |=> !pend);

  p_defer_arm_r5: assert property (@(posedge clk) disable iff (!rst_n)
    commit_later |=> pend);

  always_comb begin
    if (rst_n && rd_addr[3:2] == 2'd2) begin
      p_rd_snap_r10: assert (rd_data == 32'(snap_secs));
    end
  end
endmodule

bind pps_timebase pps_timebase_chk #(.TIME_W(TIME_W)) u_chk (
  .clk(clk), .rst_n(rst_sync_n), .now_secs(now_secs), .now_ticks(now_ticks),
  .tps(tps_q), .load_fire(load_fire), .pps_edge(pps_edge), .pend(pend_q),
  .commit_now(commit_now), .commit_later(commit_later),
  .snap_secs(snap_secs), .snap_ticks(snap_ticks),
  .rd_addr(rd_addr), .rd_data(rd_data)
);

// File: tb/pps_timebase_bench.sv
module pps_timebase_bench;
  localparam int          SYNC = 2;
  localparam logic [31:0] TPS0 = 32'd10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [2:0]  cfg_idx = 3'd0;
  logic [31:0] cfg_data = 32'd0;
  logic        pps_ext = 1'b0;
  logic        pps_alt = 1'b0;
  logic [3:0]  rd_addr = 4'd0;
  logic [31:0] rd_data, now_secs, now_ticks;

  int    checks = 0;
  int    errors = 0;
  string phase = "R1";
  bit    done = 1'b0;

  always #2 clk = ~clk;

  pps_timebase #(.TIME_W(32), .SYNC_STAGES(SYNC), .TPS_RESET(TPS0)) u_pps_timebase (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_idx(cfg_idx),
    .cfg_data(cfg_data), .pps_ext(pps_ext), .pps_alt(pps_alt),
    .rd_addr(rd_addr), .rd_data(rd_data), .now_secs(now_secs),
    .now_ticks(now_ticks)
  );

  // behavioural reference
  logic [31:0] m_secs, m_ticks, m_ss, m_st, m_tps, m_snap_s, m_snap_t;
  logic [1:0]  m_flags;
  bit          m_pend, m_prev;
  bit          m_sync [2][SYNC];
  int          m_rel;

  task automatic m_reset();
    m_secs = 0; m_ticks = 0; m_ss = 0; m_st = 0; m_tps = TPS0;
    m_snap_s = 0; m_snap_t = 0; m_flags = 2'b01; m_pend = 0; m_prev = 0;
    for (int s = 0; s < 2; s++) for (int k = 0; k < SYNC; k++) m_sync[s][k] = 0;
  endtask

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_reset();
      m_rel = 0;
    end else if (m_rel < 2) begin
      m_reset();
      m_rel++;
    end else begin
      bit sel, pe, imm, dfr, fire;
      sel  = m_flags[1] ? m_sync[1][SYNC-1] : m_sync[0][SYNC-1];
      pe   = m_flags[0] ? (sel && !m_prev) : (!sel && m_prev);
      imm  = cfg_we && cfg_idx == 3'd3 && cfg_data[0];
      dfr  = cfg_we && cfg_idx == 3'd3 && !cfg_data[0];
      fire = m_pend && pe;
      if (pe) begin m_snap_s = m_secs; m_snap_t = m_ticks; end
      if (imm || fire) begin m_secs = m_ss; m_ticks = m_st; end
      else if ({1'b0, m_ticks} + 33'd1 >= {1'b0, m_tps}) begin m_ticks = 0; m_secs = m_secs + 1; end
      else m_ticks = m_ticks + 1;
      if (dfr) m_pend = 1; else if (imm || fire) m_pend = 0;
      if (cfg_we) begin
        case (cfg_idx)
          3'd0: m_ss = cfg_data;
          3'd1: m_st = cfg_data;
          3'd2: m_flags = cfg_data[1:0];
          3'd4: m_tps = cfg_data;
          default: ;
        endcase
      end
      m_prev = sel;
      for (int s = 0; s < 2; s++) for (int k = SYNC-1; k > 0; k--) m_sync[s][k] = m_sync[s][k-1];
      m_sync[0][0] = pps_ext;
      m_sync[1][0] = pps_alt;
    end
  end

  task automatic chk(string tag, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  // comparison on every cycle, away from the active edge
  always @(negedge clk) begin
    logic [31:0] exp_rd;
    if (!done) begin
      chk(phase, "now_secs", now_secs, m_secs);
      chk(phase, "now_ticks", now_ticks, m_ticks);
      case (rd_addr[3:2])
        2'd0: exp_rd = m_secs;
        2'd1: exp_rd = m_ticks;
        2'd2: exp_rd = m_snap_s;
        default: exp_rd = m_snap_t;
      endcase
      chk(rd_addr[3] ? "R9" : "R10", "rd_data", rd_data, exp_rd);
      rd_addr <= rd_addr + 4'd3;
    end
  end

  task automatic cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(logic [2:0] idx, logic [31:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_idx = idx; cfg_data = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic pulse_ext(int hi);
    @(negedge clk); pps_ext = 1'b1;
    cyc(hi);
    pps_ext = 1'b0;
  endtask

  task automatic pulse_alt(int hi);
    @(negedge clk); pps_alt = 1'b1;
    cyc(hi);
    pps_alt = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++; errors++;
      $display("FAIL watchdog expired in phase %s", phase);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    phase = "R1";
    cyc(3);
    chk("R1", "secs in reset", now_secs, 32'd0);
    chk("R1", "ticks in reset", now_ticks, 32'd0);
    rst_n = 1'b1;
    cyc(2);
    chk("R1", "ticks held after release", now_ticks, 32'd0);
    phase = "R2";
    cyc(25);
    wr(3'd4, 32'd5);
    cyc(20);
    phase = "R3";
    wr(3'd0, 32'h0000_0100);
    wr(3'd1, 32'd2);
    wr(3'd5, 32'hFFFF_FFFF);
    wr(3'd6, 32'h1234_5678);
    cyc(8);
    phase = "R4";
    wr(3'd3, 32'd1);
    cyc(12);
    phase = "R5";
    wr(3'd0, 32'h0000_0200);
    wr(3'd1, 32'd1);
    wr(3'd3, 32'd0);
    cyc(10);
    phase = "R6";
    pulse_ext(4);
    cyc(10);
    phase = "R9";
    pulse_ext(3);
    cyc(10);
    phase = "R7";
    wr(3'd2, 32'd0);
    wr(3'd0, 32'h0000_0300);
    wr(3'd3, 32'd0);
    pulse_ext(5);
    cyc(10);
    phase = "R8";
    wr(3'd2, 32'd3);
    wr(3'd4, 32'd7);
    wr(3'd0, 32'h0000_0400);
    wr(3'd3, 32'd0);
    pulse_ext(3);
    cyc(8);
    pulse_alt(3);
    cyc(10);
    phase = "R11";
    wr(3'd0, 32'h0000_0500);
    wr(3'd3, 32'd0);
    wr(3'd0, 32'h0000_0600);
    wr(3'd3, 32'd1);
    pulse_alt(3);
    cyc(8);
    @(negedge clk); pps_alt = 1'b1;
    @(negedge clk);
    cfg_we = 1'b1; cfg_idx = 3'd3; cfg_data = 32'd0;
    @(negedge clk); cfg_we = 1'b0;
    cyc(4);
    pps_alt = 1'b0;
    cyc(4);
    pulse_alt(2);
    cyc(12);
    phase = "R10";
    cyc(16);
    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule